// File: doc/BRIEF.md
# Immediate and Register ALU

This block is the 32-bit execute stage of a small command-processor microcontroller. Each cycle in which `in_valid` is high it accepts one decoded operation: a 5-bit operation code, the value of source register 1, and a second operand. The second operand is either the value of source register 2 (two-register form) or a zero-extended 16-bit immediate (immediate form). A 5-bit shift field serves the move-immediate operation. One clock edge later the block presents a 32-bit result, a write-enable and the 5-bit destination index for the register file. The register file, fetch and branching sit outside this block.

A single carry flag lets software build 64-bit add and subtract from two 32-bit steps. The low half is an ADD or SUB. The high half is an ADDHI or SUBHI, which consumes the flag the low half left behind. Besides the usual logic and shift operations, the block offers an 8-bit multiply, unsigned min/max/compare, a shifted move-immediate and a highest-set-bit index.

Control is a two-state machine. `ST_IDLE` means no result is on the outputs. `ST_RESULT` means the outputs carry the result of the operation issued on the previous edge. There are four transitions:
- `ST_IDLE` to `ST_RESULT` on an issue (`in_valid` high).
- `ST_RESULT` to `ST_RESULT` on a back-to-back issue.
- `ST_RESULT` to `ST_IDLE` when no issue arrives.
- `ST_IDLE` to `ST_IDLE` while no issue arrives.

Top module: `cp_alu`

## Requirements
- R1: After reset, `res_valid`, `res_we` and `carry_flag` are all 0.
- R2: An operation issued on a clock edge (`in_valid` high) gives `res_valid` high after that edge, with `res_dst` equal to the issued `dst_idx`. A cycle with no issue gives `res_valid` low after the next edge.
- R3: In the immediate form (`use_reg`=0), the second operand is `imm16` zero-extended to 32 bits. In the two-register form (`use_reg`=1), it is `src2_val`.
- R4: ADD (0x01) writes `src1 + op2` modulo 2^32 and sets the carry to the carry-out. SUB (0x03) writes `src1 - op2` modulo 2^32 and sets the carry to 1 when no borrow occurred (`src1 >= op2` unsigned), 0 otherwise.
- R5: ADDHI (0x02) writes `src1 + op2 + carry` and stores the new carry-out. SUBHI (0x04) writes `src1 - op2 - (1 - carry)` and stores the new no-borrow flag, so that two steps form a 64-bit add or subtract.
- R6: The carry flag changes only on an issued ADD, ADDHI, SUB or SUBHI. It holds its value across every other operation and across idle cycles.
- R7: AND (0x05), OR (0x06) and XOR (0x07) combine `src1` and op2 bitwise. NOT (0x08) writes `~op2` and ignores `src1`.
- R8: SHL (0x09), USHR (0x0a), ISHR (0x0b) and ROT (0x0c) shift `src1` by `op2[4:0]`. SHL shifts left with zero fill. USHR shifts right with zero fill. ISHR shifts right and copies bit 31 into the vacated bits. ROT rotates left, wrapping bits from the top into the bottom.
- R9: MUL8 (0x0d) writes the unsigned product of `src1[7:0]` and `op2[7:0]`, zero-extended to 32 bits.
- R10: MIN (0x0e) and MAX (0x0f) write the unsigned smaller and larger of `src1` and op2. CMP (0x10) writes 0 when they are equal, 1 when `src1` is greater and 2 when `src1` is smaller, all compared unsigned.
- R11: MOVI (0x11), in the immediate form only, writes `imm16` shifted left by `movi_shift` (the bits shifted past bit 31 are lost). Issued in the two-register form, it does not write (`res_we`=0).
- R12: MSB (0x14), in the two-register form only, writes the index of the highest set bit of `src2_val`, and 0 when `src2_val` is 0. Issued in the immediate form, it does not write.
- R13: Every other code (0x00, 0x12, 0x13, 0x15 to 0x1f) produces `res_valid`=1 with `res_we`=0. `res_we` is never high while `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is issued this cycle |
| use_reg | input | 1 | 1 = two-register form, 0 = immediate form |
| op_code | input | 5 | Decoded ALU operation code |
| src1_val | input | 32 | Value of source register 1 |
| src2_val | input | 32 | Value of source register 2 (two-register form) |
| imm16 | input | 16 | Unsigned immediate (immediate form) |
| movi_shift | input | 5 | Left-shift amount for MOVI |
| dst_idx | input | 5 | Destination register index |
| res_valid | output | 1 | Result stage holds an issued operation |
| res_we | output | 1 | Register-file write enable |
| res_dst | output | 5 | Destination register index of the result |
| res_data | output | 32 | Result value |
| carry_flag | output | 1 | Carry / no-borrow flag for chained 64-bit arithmetic |

## Verification
Every result, and any carry update, appears exactly one clock edge after the edge that captures the issue. There is no combinational path from inputs to outputs. The bench therefore changes inputs on the falling edge, lets one rising edge pass, and compares all outputs 1 ns after that edge, before the next input change. Idle cycles are checked the same way: one edge after `in_valid` falls, `res_valid` must be low and `carry_flag` unchanged. Chained 64-bit cases are checked across two consecutive issues, with the expected carry carried forward in the bench model.

// File: rtl/cp_alu_pkg.sv
package cp_alu_pkg;

    localparam int OPC_W = 5;

    localparam logic [OPC_W-1:0] OP_ADD   = 5'h01;
    localparam logic [OPC_W-1:0] OP_ADDHI = 5'h02;
    localparam logic [OPC_W-1:0] OP_SUB   = 5'h03;
    localparam logic [OPC_W-1:0] OP_SUBHI = 5'h04;
    localparam logic [OPC_W-1:0] OP_AND   = 5'h05;
    localparam logic [OPC_W-1:0] OP_OR    = 5'h06;
    localparam logic [OPC_W-1:0] OP_XOR   = 5'h07;
    localparam logic [OPC_W-1:0] OP_NOT   = 5'h08;
    localparam logic [OPC_W-1:0] OP_SHL   = 5'h09;
    localparam logic [OPC_W-1:0] OP_USHR  = 5'h0a;
    localparam logic [OPC_W-1:0] OP_ISHR  = 5'h0b;
    localparam logic [OPC_W-1:0] OP_ROT   = 5'h0c;
    localparam logic [OPC_W-1:0] OP_MUL8  = 5'h0d;
    localparam logic [OPC_W-1:0] OP_MIN   = 5'h0e;
    localparam logic [OPC_W-1:0] OP_MAX   = 5'h0f;
    localparam logic [OPC_W-1:0] OP_CMP   = 5'h10;
    localparam logic [OPC_W-1:0] OP_MOVI  = 5'h11;
    localparam logic [OPC_W-1:0] OP_MSB   = 5'h14;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } alu_state_e;

    function automatic logic is_carry_op(input logic [OPC_W-1:0] op);
        return (op == OP_ADD) || (op == OP_ADDHI) ||
               (op == OP_SUB) || (op == OP_SUBHI);
    endfunction

endpackage

// File: rtl/cp_alu_opnd.sv
module cp_alu_opnd #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              use_reg,
    input  logic [DATA_W-1:0] src2_val,
    input  logic [IMM_W-1:0]  imm16,
    output logic [DATA_W-1:0] op2
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        if (use_reg) op2 = src2_val;
        else         op2 = {{PAD_W{1'b0}}, imm16};
    end
endmodule

// File: rtl/cp_alu_arith.sv
module cp_alu_arith
    import cp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_in,
    output logic              hit,
    output logic [DATA_W-1:0] sum,
    output logic              carry_out
);
    logic              subtract;
    logic              cin;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full;

    always_comb begin
        hit      = is_carry_op(op_code);
        subtract = (op_code == OP_SUB) || (op_code == OP_SUBHI);
        unique case (op_code)
            OP_ADD:          cin = 1'b0;
            OP_SUB:          cin = 1'b1;
            OP_ADDHI,
            OP_SUBHI:        cin = carry_in;
            default:         cin = 1'b0;
        endcase
        b_eff     = subtract ? ~b : b;
        full      = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        sum       = full[DATA_W-1:0];
        carry_out = full[DATA_W];
    end
endmodule

// File: rtl/cp_alu_logic.sv
module cp_alu_logic
    import cp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int MUL_W  = 8
) (
    input  logic [OPC_W-1:0]         op_code,
    input  logic                     use_reg,
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  logic [IMM_W-1:0]         imm16,
    input  logic [$clog2(DATA_W)-1:0] movi_shift,
    output logic                     hit,
    output logic [DATA_W-1:0]        result
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int PROD_W = 2 * MUL_W;

    logic [SH_W-1:0]     sh;
    logic [2*DATA_W-1:0] rot_wide;
    logic [PROD_W-1:0]   prod;
    logic [DATA_W-1:0]   msb_idx;
    logic [DATA_W-1:0]   imm_ext;

    always_comb begin
        sh       = b[SH_W-1:0];
        rot_wide = {a, a} << sh;
        prod     = a[MUL_W-1:0] * b[MUL_W-1:0];
        imm_ext  = {{(DATA_W-IMM_W){1'b0}}, imm16};
        msb_idx  = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (b[i]) msb_idx = DATA_W'(i);
        end
    end

    always_comb begin
        hit    = 1'b1;
        result = '0;
        unique case (op_code)
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_XOR:  result = a ^ b;
            OP_NOT:  result = ~b;
            OP_SHL:  result = a << sh;
            OP_USHR: result = a >> sh;
            OP_ISHR: result = $unsigned($signed(a) >>> sh);
            OP_ROT:  result = rot_wide[2*DATA_W-1:DATA_W];
            OP_MUL8: result = {{(DATA_W-PROD_W){1'b0}}, prod};
            OP_MIN:  result = (a < b) ? a : b;
            OP_MAX:  result = (a > b) ? a : b;
            OP_CMP: begin
                if (a == b)     result = DATA_W'(0);
                else if (a > b) result = DATA_W'(1);
                else            result = DATA_W'(2);
            end
            OP_MOVI: begin
                hit    = !use_reg;
                result = imm_ext << movi_shift;
            end
            OP_MSB: begin
                hit    = use_reg;
                result = msb_idx;
            end
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        if (op_code == OP_NOT)
            assert_not_ignores_src1_R7: assert (result == ~b);
    end
endmodule

// File: rtl/cp_alu.sv
module cp_alu
    import cp_alu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 16,
    parameter int REG_IDX_W = 5,
    parameter int MUL_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      use_reg,
    input  logic [4:0]                op_code,
    input  logic [DATA_W-1:0]         src1_val,
    input  logic [DATA_W-1:0]         src2_val,
    input  logic [IMM_W-1:0]          imm16,
    input  logic [$clog2(DATA_W)-1:0] movi_shift,
    input  logic [REG_IDX_W-1:0]      dst_idx,
    output logic                      res_valid,
    output logic                      res_we,
    output logic [REG_IDX_W-1:0]      res_dst,
    output logic [DATA_W-1:0]         res_data,
    output logic                      carry_flag
);
    alu_state_e state_q, state_d;

    logic [DATA_W-1:0] op2;
    logic              ar_hit, lg_hit, ar_cout;
    logic [DATA_W-1:0] ar_sum, lg_res;

    cp_alu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .use_reg  (use_reg),
        .src2_val (src2_val),
        .imm16    (imm16),
        .op2      (op2)
    );

    cp_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op_code   (op_code),
        .a         (src1_val),
        .b         (op2),
        .carry_in  (carry_flag),
        .hit       (ar_hit),
        .sum       (ar_sum),
        .carry_out (ar_cout)
    );

    cp_alu_logic #(.DATA_W(DATA_W), .IMM_W(IMM_W), .MUL_W(MUL_W)) u_logic (
        .op_code    (op_code),
        .use_reg    (use_reg),
        .a          (src1_val),
        .b          (op2),
        .imm16      (imm16),
        .movi_shift (movi_shift),
        .hit        (lg_hit),
        .result     (lg_res)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_we     <= 1'b0;
            res_dst    <= '0;
            res_data   <= '0;
            carry_flag <= 1'b0;
        end else if (in_valid) begin
            res_we   <= ar_hit | lg_hit;
            res_dst  <= dst_idx;
            res_data <= ar_hit ? ar_sum : lg_res;
            if (ar_hit) carry_flag <= ar_cout;
        end else begin
            res_we <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_RESULT);

    assert_valid_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    assert_we_inside_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> res_valid);
    assert_carry_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && is_carry_op(op_code)) |=> $stable(carry_flag));
    assert_msb_imm_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_reg && op_code == OP_MSB) |=> !res_we);
    assert_movi_reg_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_reg && op_code == OP_MOVI) |=> !res_we);
endmodule

// File: tb/cp_alu_tb.sv
module cp_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        use_reg = 1'b0;
    logic [4:0]  op_code = '0;
    logic [31:0] src1_val = '0;
    logic [31:0] src2_val = '0;
    logic [15:0] imm16 = '0;
    logic [4:0]  movi_shift = '0;
    logic [4:0]  dst_idx = '0;
    logic        res_valid, res_we, carry_flag;
    logic [4:0]  res_dst;
    logic [31:0] res_data;

    int n_vec = 0;
    int n_bad = 0;
    logic m_carry = 1'b0;

    always #2 clk = ~clk;

    cp_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_reg(use_reg),
        .op_code(op_code), .src1_val(src1_val), .src2_val(src2_val),
        .imm16(imm16), .movi_shift(movi_shift), .dst_idx(dst_idx),
        .res_valid(res_valid), .res_we(res_we), .res_dst(res_dst),
        .res_data(res_data), .carry_flag(carry_flag)
    );

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'h01, 5'h03:                 return "R4";
            5'h02, 5'h04:                 return "R5";
            5'h05, 5'h06, 5'h07, 5'h08:   return "R7";
            5'h09, 5'h0a, 5'h0b, 5'h0c:   return "R8";
            5'h0d:                        return "R9";
            5'h0e, 5'h0f, 5'h10:          return "R10";
            5'h11:                        return "R11";
            5'h14:                        return "R12";
            default:                      return "R13";
        endcase
    endfunction

    task automatic check(input string tag, input logic v, input logic we,
                         input logic [4:0] d, input logic [31:0] r, input logic c);
        n_vec++;
        if (res_valid !== v || res_we !== we || carry_flag !== c ||
            (we && (res_data !== r || res_dst !== d))) begin
            n_bad++;
            $display("FAIL %s: got v=%0b we=%0b dst=%0d data=%h c=%0b, expected v=%0b we=%0b dst=%0d data=%h c=%0b",
                     tag, res_valid, res_we, res_dst, res_data, carry_flag, v, we, d, r, c);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic rf, input logic [31:0] a,
                         input logic [31:0] b2, input logic [15:0] im,
                         input logic [4:0] sh, input logic [4:0] d, input string tag_in);
        logic [31:0] b, r;
        logic we, c;
        logic [63:0] t;
        string tag;
        tag = (tag_in == "") ? tag_of(op) : tag_in;
        b  = rf ? b2 : {16'h0, im};          // R3 operand choice
        we = 1'b1; r = '0; c = m_carry;
        case (op)
            5'h01: begin t = 64'(a) + 64'(b); r = t[31:0]; c = t[32]; end
            5'h02: begin t = 64'(a) + 64'(b) + 64'(m_carry); r = t[31:0]; c = t[32]; end
            5'h03: begin r = a - b; c = (a >= b); end
            5'h04: begin
                t = 64'(b) + 64'(!m_carry);
                r = a - b - 32'(!m_carry); c = (64'(a) >= t);
            end
            5'h05: r = a & b;
            5'h06: r = a | b;
            5'h07: r = a ^ b;
            5'h08: r = ~b;
            5'h09: r = a * (32'd1 << b[4:0]);
            5'h0a: r = a / (33'd1 << b[4:0]);
            5'h0b: begin
                r = a / (33'd1 << b[4:0]);
                for (int k = 0; k < 32; k++) if (a[31] && k >= 32 - b[4:0]) r[k] = 1'b1;
            end
            5'h0c: for (int k = 0; k < 32; k++) r[(k + b[4:0]) % 32] = a[k];
            5'h0d: r = 32'(a[7:0]) * 32'(b[7:0]);
            5'h0e: r = (a <= b) ? a : b;
            5'h0f: r = (a >= b) ? a : b;
            5'h10: r = (a == b) ? 0 : ((a > b) ? 1 : 2);
            5'h11: begin we = !rf; t = 64'(im) * (64'd1 << sh); r = t[31:0]; end
            5'h14: begin
                we = rf;
                for (int k = 0; k < 32; k++) if (b[k]) r = k;
            end
            default: we = 1'b0;
        endcase
        @(negedge clk);
        in_valid = 1'b1; op_code = op; use_reg = rf; src1_val = a;
        src2_val = b2; imm16 = im; movi_shift = sh; dst_idx = d;
        @(posedge clk); #1;
        m_carry = c;
        check(tag, 1'b1, we, d, r, m_carry);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        op_code = 5'h01;  // an adding code while idle must not move the carry (R6)
        @(posedge clk); #1;
        check("R2/R6 idle", 1'b0, 1'b0, '0, '0, m_carry);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pat [12];
        pat = '{32'h0, 32'h1, 32'h2, 32'h7f, 32'h80, 32'hff, 32'h7fffffff,
                32'h80000000, 32'hfffffffe, 32'hffffffff, 32'h1234abcd, 32'h0000ffff};
        repeat (3) @(posedge clk);
        #1 check("R1 reset", 1'b0, 1'b0, '0, '0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 check("R1 after release", 1'b0, 1'b0, '0, '0, 1'b0);

        for (int op = 0; op < 32; op++)
            for (int rf = 0; rf < 2; rf++)
                for (int i = 0; i < 12; i++)
                    for (int j = 0; j < 12; j++)
                        apply(5'(op), 1'(rf), pat[i], pat[j], pat[j][15:0],
                              5'(i + j), 5'(op + i), "");

        for (int s = 0; s < 32; s++) apply(5'h11, 1'b0, '0, '0, 16'hbeef, 5'(s), 5'd3, "R11");
        for (int s = 0; s < 32; s++) apply(5'h0b, 1'b1, 32'h80000001, 32'(s), '0, '0, 5'd4, "R8");
        for (int s = 0; s < 32; s++) apply(5'h14, 1'b1, '0, 32'd1 << s, '0, '0, 5'd5, "R12");

        // 64-bit chains
        apply(5'h01, 1'b1, 32'hffffffff, 32'h1, '0, '0, 5'd6, "R4");
        apply(5'h02, 1'b1, 32'h0, 32'h0, '0, '0, 5'd7, "R5");
        apply(5'h03, 1'b1, 32'h0, 32'h1, '0, '0, 5'd8, "R4");
        apply(5'h04, 1'b1, 32'h5, 32'h0, '0, '0, 5'd9, "R5");
        apply(5'h03, 1'b0, 32'h10, 32'h0, 16'h10, '0, 5'd10, "R3");
        apply(5'h04, 1'b0, 32'h0, 32'h0, 16'h0, '0, 5'd11, "R5");
        apply(5'h01, 1'b1, 32'h80000000, 32'h80000000, '0, '0, 5'd12, "R4");
        apply(5'h05, 1'b1, 32'hf0f0f0f0, 32'hffffffff, '0, '0, 5'd13, "R6");
        apply(5'h02, 1'b1, 32'h1, 32'h1, '0, '0, 5'd14, "R5");
        apply(5'h01, 1'b1, 32'hffffffff, 32'h1, '0, '0, 5'd15, "R4");
        idle_cycle();
        idle_cycle();
        apply(5'h02, 1'b1, 32'h0, 32'h0, '0, '0, 5'd16, "R6");
        idle_cycle();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule